// File: doc/BRIEF.md
# Single-Cycle Load/Store RISC Core

This block is a 32-bit processor core that completes one fixed-width instruction in each clock cycle. Every cycle it presents a word address to an instruction port and receives a 32-bit instruction on the same cycle. It decodes the instruction and reads two operands from a 32-entry register file. It then computes a result in the ALU, optionally touches a word-addressed data port, writes the register file, and selects the next program counter. Both memory ports read combinationally. The data port writes on the rising clock edge while its write strobe is high.

The supported operations are:

- Register-register arithmetic, logic and shifts.
- Immediate arithmetic and logic, plus an upper-half constant load.
- Word load and word store.
- A load that also writes the computed address back into its base register.
- Equal and not-equal branches.
- Absolute jump, jump-and-link, and jump through a register.

The core is meant to sit beside small instruction and data memories. A program is started by holding reset for one or more cycles.

Top module: `scpu_core`

## Requirements
- R1: `rst` is synchronous and active high. At the first rising edge with `rst` high, the PC becomes 0, so `imemWordAddr` reads 0 from that cycle on.
- R2: `imemWordAddr` is PC bits [31:2]. An instruction that is neither a branch nor a jump advances the PC by 4, which is one word.
- R3: Instruction fields, from bit 31 down, are opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. Opcode 000000 selects register-register operations, which write rd. The funct codes are add 100000, sub 100010, and 100100, and or 100101.
- R4: slt (funct 101010) writes 1 to rd when rs is less than rt as signed values, and writes 0 otherwise.
- R5: sll (funct 000000) and srl (funct 000010) shift rt by shamt and write the result to rd. srl fills with zeros.
- R6: The immediate is bits [15:0] and results go to rt. addi (001000) sign-extends the immediate. andi (001100) and ori (001101) zero-extend it. lui (001111) writes the immediate into bits [31:16] and zeros into bits [15:0].
- R7: Register 0 always reads as 0, and writes to it are discarded.
- R8: lw (100011) loads rt from data word (rs + sign-extended offset) >> 2. sw (101011) stores rt at that word. `dmemWrEn` is high only for sw.
- R9: The update load (opcode 110011) loads rt from the word at rs + sign-extended offset, and writes that address into rs. When rt equals rs, the loaded data is the value kept.
- R10: beq (000100) and bne (000101) compare rs with rt. When taken, the next PC is the branch's own PC + (sign-extended offset << 2). When not taken, the PC advances by 4.
- R11: j (000010) and jal (000011) set the PC to {(PC+4)[31:28], target[25:0], 2'b00}. jal also writes PC+4 into register 31.
- R12: jr (opcode 000000, funct 001000) loads the PC from rs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemWordAddr | output | 30 | Word address of the current instruction |
| instr | input | 32 | Instruction read at `imemWordAddr` |
| dmemWordAddr | output | 30 | Word address for a data load or store |
| dmemWrEn | output | 1 | Store strobe, written on the rising edge |
| dmemWrData | output | 32 | Data to store |
| dmemRdData | input | 32 | Data read at `dmemWordAddr` |

## Verification
An error in the PC register or in next-PC selection shows up on `imemWordAddr` on the very next cycle. A wrong branch target or wrong link value instead shows up later: the program visits addresses it should skip, or stores a wrong return address. A corrupted register, or a lost base update, stays hidden until a later store puts that register on `dmemWrData`. The test program therefore stores every computed register soon after producing it, so such faults reach memory within a few instructions. An illegal write strobe is visible at once on `dmemWrEn`.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JAL   = 6'b000011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_LWUPD = 6'b110011;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    aluOp_e aluOp;
    logic   useImm;
    logic   immZero;
    logic   regDstRd;
    logic   regWrite;
    logic   link;
    logic   memToReg;
    logic   memWrite;
    logic   baseUpdate;
    logic   branch;
    logic   branchNe;
    logic   jump;
    logic   jumpReg;
  } ctrl_t;

endpackage

// File: rtl/scp_control.sv
module scp_control
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.regWrite = 1'b1;
        ctrl.regDstRd = 1'b1;
        case (funct)
          FN_ADD: ctrl.aluOp = ALU_ADD;
          FN_SUB: ctrl.aluOp = ALU_SUB;
          FN_AND: ctrl.aluOp = ALU_AND;
          FN_OR:  ctrl.aluOp = ALU_OR;
          FN_SLT: ctrl.aluOp = ALU_SLT;
          FN_SLL: ctrl.aluOp = ALU_SLL;
          FN_SRL: ctrl.aluOp = ALU_SRL;
          FN_JR: begin
            ctrl.regWrite = 1'b0;
            ctrl.jumpReg  = 1'b1;
          end
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
      end
      OP_ANDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.immZero  = 1'b1;
        ctrl.aluOp    = ALU_AND;
      end
      OP_ORI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.immZero  = 1'b1;
        ctrl.aluOp    = ALU_OR;
      end
      OP_LUI: begin
        ctrl.regWrite = 1'b1;
        ctrl.aluOp    = ALU_LUI;
      end
      OP_LW: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      OP_LWUPD: begin
        ctrl.regWrite   = 1'b1;
        ctrl.useImm     = 1'b1;
        ctrl.memToReg   = 1'b1;
        ctrl.baseUpdate = 1'b1;
      end
      OP_SW: begin
        ctrl.useImm   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: ctrl.branch = 1'b1;
      OP_BNE: begin
        ctrl.branch   = 1'b1;
        ctrl.branchNe = 1'b1;
      end
      OP_J: ctrl.jump = 1'b1;
      OP_JAL: begin
        ctrl.jump     = 1'b1;
        ctrl.link     = 1'b1;
        ctrl.regWrite = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter  int DATA_W = 32,
  parameter  int REG_N  = 32,
  localparam int REG_AW = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEnMain,
  input  logic [REG_AW-1:0] wrAddrMain,
  input  logic [DATA_W-1:0] wrDataMain,
  input  logic              wrEnAux,
  input  logic [REG_AW-1:0] wrAddrAux,
  input  logic [DATA_W-1:0] wrDataAux
);

  logic [DATA_W-1:0] regs [REG_N];

  // aux port is scheduled first, so the main port wins on equal addresses
  always_ff @(posedge clk) begin
    if (wrEnAux && wrAddrAux != '0) regs[wrAddrAux] <= wrDataAux;
    if (wrEnMain && wrAddrMain != '0) regs[wrAddrMain] <= wrDataMain;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/scp_datapath.sv
module scp_datapath
  import scp_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int REG_N  = 32,
  localparam int REG_AW = $clog2(REG_N),
  localparam int WORD_W = DATA_W - 2,
  localparam int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] dmemRdData,
  output logic [DATA_W-1:0] pc,
  output logic [WORD_W-1:0] dmemWordAddr,
  output logic [DATA_W-1:0] dmemWrData,
  output logic              dmemWrEn
);

  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wbIdx;
  logic [4:0]        shamt;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] rsVal, rtVal, immExt, opB, aluRes, wbData;
  logic [DATA_W-1:0] pcPlus4, brTarget, jTarget, pcNext;
  logic              takeBranch;
  logic [1:0]        unusedLowBits;

  assign rsIdx = instr[21 +: REG_AW];
  assign rtIdx = instr[16 +: REG_AW];
  assign rdIdx = instr[11 +: REG_AW];
  assign shamt = instr[10:6];
  assign imm   = instr[IMM_W-1:0];

  assign immExt = ctrl.immZero ? {{(DATA_W-IMM_W){1'b0}}, imm}
                               : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign opB = ctrl.useImm ? immExt : rtVal;

  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD: aluRes = rsVal + opB;
      ALU_SUB: aluRes = rsVal - opB;
      ALU_AND: aluRes = rsVal & opB;
      ALU_OR:  aluRes = rsVal | opB;
      ALU_SLT: aluRes = {{(DATA_W-1){1'b0}}, $signed(rsVal) < $signed(opB)};
      ALU_SLL: aluRes = rtVal << shamt;
      ALU_SRL: aluRes = rtVal >> shamt;
      default: aluRes = {imm, {(DATA_W-IMM_W){1'b0}}};
    endcase
  end

  assign wbIdx  = ctrl.link ? REG_AW'(REG_N - 1) : (ctrl.regDstRd ? rdIdx : rtIdx);
  assign wbData = ctrl.link ? pcPlus4 : (ctrl.memToReg ? dmemRdData : aluRes);

  scp_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_regs (
    .clk       (clk),
    .rdAddrA   (rsIdx),
    .rdAddrB   (rtIdx),
    .rdDataA   (rsVal),
    .rdDataB   (rtVal),
    .wrEnMain  (ctrl.regWrite),
    .wrAddrMain(wbIdx),
    .wrDataMain(wbData),
    .wrEnAux   (ctrl.baseUpdate),
    .wrAddrAux (rsIdx),
    .wrDataAux (aluRes)
  );

  assign pcPlus4    = pc + DATA_W'(4);
  assign brTarget   = pc + {immExt[DATA_W-3:0], 2'b00};
  assign jTarget    = {pcPlus4[DATA_W-1:28], instr[25:0], 2'b00};
  assign takeBranch = ctrl.branch && ((rsVal == rtVal) ^ ctrl.branchNe);

  always_comb begin
    if (ctrl.jumpReg)   pcNext = rsVal;
    else if (ctrl.jump) pcNext = jTarget;
    else if (takeBranch) pcNext = brTarget;
    else                pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign dmemWordAddr  = aluRes[DATA_W-1:2];
  assign unusedLowBits = aluRes[1:0];
  assign dmemWrData    = rtVal;
  assign dmemWrEn      = ctrl.memWrite;

endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scp_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int REG_N  = 32,
  localparam int WORD_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] imemWordAddr,
  input  logic [31:0]       instr,
  output logic [WORD_W-1:0] dmemWordAddr,
  output logic              dmemWrEn,
  output logic [DATA_W-1:0] dmemWrData,
  input  logic [DATA_W-1:0] dmemRdData
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] pc;
  logic [1:0]        unusedPcLow;

  scp_control u_ctrl (
    .opcode(instr[31:26]),
    .funct (instr[5:0]),
    .ctrl  (ctrl)
  );

  scp_datapath #(.DATA_W(DATA_W), .REG_N(REG_N)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .instr       (instr),
    .ctrl        (ctrl),
    .dmemRdData  (dmemRdData),
    .pc          (pc),
    .dmemWordAddr(dmemWordAddr),
    .dmemWrData  (dmemWrData),
    .dmemWrEn    (dmemWrEn)
  );

  assign imemWordAddr = pc[DATA_W-1:2];
  assign unusedPcLow  = pc[1:0];

endmodule

// File: rtl/scpu_core_checker.sv
module scpu_core_checker
  import scp_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] imemWordAddr,
  input logic [31:0]       instr,
  input logic              dmemWrEn
);

  logic [5:0]        op;
  logic              isJr, isBranch, isJump, isFlow;
  logic [WORD_W-1:0] seqAddr, brAddr;

  assign op       = instr[31:26];
  assign isJr     = (op == OP_RTYPE) && (instr[5:0] == FN_JR);
  assign isBranch = (op == OP_BEQ) || (op == OP_BNE);
  assign isJump   = (op == OP_J) || (op == OP_JAL);
  assign isFlow   = isJr || isBranch || isJump;
  assign seqAddr  = imemWordAddr + WORD_W'(1);
  assign brAddr   = imemWordAddr + {{(WORD_W-16){instr[15]}}, instr[15:0]};

  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> imemWordAddr == '0);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    !isFlow |=> imemWordAddr == $past(seqAddr));

  a_r10_branch_target: assert property (@(posedge clk) disable iff (rst)
    isBranch |=> (imemWordAddr == $past(seqAddr)) || (imemWordAddr == $past(brAddr)));

  a_r11_jump_target: assert property (@(posedge clk) disable iff (rst)
    isJump |=> imemWordAddr == {$past(seqAddr[WORD_W-1:26]), $past(instr[25:0])});

  always_comb begin
    if (!rst) begin
      a_r8_store_strobe: assert (dmemWrEn == (op == OP_SW));
    end
  end

endmodule

bind scpu_core scpu_core_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .imemWordAddr(imemWordAddr),
  .instr       (instr),
  .dmemWrEn    (dmemWrEn)
);

// File: tb/scpu_core_test.sv
module scpu_core_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALT_WORD  = 59;
  localparam int  N_EXP      = 20;
  localparam logic [31:0] EXP_MEM [N_EXP] = '{
    32'd2, 32'd8, 32'd5, 32'hFFFFFFFD, 32'd1, 32'd0, 32'h50, 32'hF,
    32'h12348001, 32'h0000FFF0, 32'd0, 32'h22222222, 32'h33333333,
    32'd88, 32'h11111111, 32'd3, 32'd3, 32'd9, 32'd7, 32'd196};

  logic        clk = 1'b0;
  logic        rst;
  logic [29:0] imemWordAddr, dmemWordAddr;
  logic [31:0] instr, dmemWrData, dmemRdData;
  logic        dmemWrEn;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int checks = 0, failures = 0, wrCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign instr      = imem[imemWordAddr[5:0]];
  assign dmemRdData = dmem[dmemWordAddr[5:0]];

  always @(posedge clk) begin
    if (!rst && dmemWrEn) begin
      dmem[dmemWordAddr[5:0]] <= dmemWrData;
      wrCount <= wrCount + 1;
    end
  end

  scpu_core uut (
    .clk(clk), .rst(rst), .imemWordAddr(imemWordAddr), .instr(instr),
    .dmemWordAddr(dmemWordAddr), .dmemWrEn(dmemWrEn),
    .dmemWrData(dmemWrData), .dmemRdData(dmemRdData));

  function automatic logic [31:0] rEnc(int fn, int rs, int rt, int rd, int sh);
    return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] iEnc(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jEnc(int op, int target);
    return {6'(op), 26'(target)};
  endfunction

  function automatic string tagFor(int k);
    case (k)
      4, 5:           return "R4";
      6, 7:           return "R5";
      8, 9:           return "R6";
      10:             return "R7";
      11:             return "R8";
      12, 13, 14:     return "R9";
      15, 16:         return "R10";
      17:             return "R12";
      18, 19:         return "R11";
      default:        return "R3";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic loadProgram();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[10] = 32'hDEAD0000;
    dmem[20] = 32'h11111111;
    dmem[21] = 32'h22222222;
    dmem[22] = 32'h33333333;
    imem[0]  = iEnc(8'h08, 0, 1, 5);
    imem[1]  = iEnc(8'h08, 0, 2, -3);
    imem[2]  = rEnc(8'h20, 1, 2, 3, 0);
    imem[3]  = rEnc(8'h22, 1, 2, 4, 0);
    imem[4]  = rEnc(8'h24, 1, 2, 5, 0);
    imem[5]  = rEnc(8'h25, 1, 2, 6, 0);
    imem[6]  = rEnc(8'h2A, 2, 1, 7, 0);
    imem[7]  = rEnc(8'h2A, 1, 2, 8, 0);
    imem[8]  = rEnc(8'h00, 0, 1, 9, 4);
    imem[9]  = rEnc(8'h02, 0, 2, 10, 28);
    imem[10] = iEnc(8'h0F, 0, 11, 16'h1234);
    imem[11] = iEnc(8'h0D, 11, 11, 16'h8001);
    imem[12] = iEnc(8'h0C, 2, 12, 16'hFFF0);
    imem[13] = iEnc(8'h08, 0, 0, 7);
    for (int k = 0; k < 11; k++) imem[14+k] = iEnc(8'h2B, 0, (k == 10) ? 0 : 3 + k, 4*k);
    imem[25] = iEnc(8'h08, 0, 13, 80);
    imem[26] = iEnc(8'h23, 13, 14, 4);
    imem[27] = iEnc(8'h33, 13, 15, 8);
    imem[28] = iEnc(8'h2B, 0, 14, 44);
    imem[29] = iEnc(8'h2B, 0, 15, 48);
    imem[30] = iEnc(8'h2B, 0, 13, 52);
    imem[31] = iEnc(8'h33, 13, 13, -8);
    imem[32] = iEnc(8'h2B, 0, 13, 56);
    imem[33] = iEnc(8'h04, 1, 2, 3);
    imem[34] = iEnc(8'h08, 0, 16, 1);
    imem[35] = iEnc(8'h04, 1, 1, 3);
    imem[36] = iEnc(8'h08, 16, 16, 100);
    imem[37] = iEnc(8'h08, 16, 16, 100);
    imem[38] = iEnc(8'h05, 1, 1, 2);
    imem[39] = iEnc(8'h08, 16, 16, 2);
    imem[40] = iEnc(8'h05, 1, 2, 2);
    imem[41] = iEnc(8'h08, 16, 16, 100);
    imem[42] = iEnc(8'h2B, 0, 16, 60);
    imem[43] = iEnc(8'h08, 0, 17, 0);
    imem[44] = iEnc(8'h08, 0, 18, 3);
    imem[45] = iEnc(8'h08, 17, 17, 1);
    imem[46] = iEnc(8'h05, 17, 18, -1);
    imem[47] = iEnc(8'h2B, 0, 17, 64);
    imem[48] = jEnc(8'h03, 52);
    imem[49] = iEnc(8'h08, 0, 19, 9);
    imem[50] = jEnc(8'h02, 56);
    imem[51] = iEnc(8'h08, 0, 19, 100);
    imem[52] = iEnc(8'h08, 0, 20, 7);
    imem[53] = rEnc(8'h08, 31, 0, 0, 0);
    imem[54] = iEnc(8'h08, 0, 19, 100);
    imem[55] = iEnc(8'h08, 0, 19, 100);
    imem[56] = iEnc(8'h2B, 0, 19, 68);
    imem[57] = iEnc(8'h2B, 0, 20, 72);
    imem[58] = iEnc(8'h2B, 0, 31, 76);
    imem[59] = jEnc(8'h02, HALT_WORD);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cycles;
    int skippedVisits;
    bit halted;
    rst = 1'b1;
    loadProgram();
    repeat (3) @(negedge clk);
    check("R1", "word address in reset", {2'b0, imemWordAddr}, 32'd0);
    rst = 1'b0;

    cycles = 0;
    skippedVisits = 0;
    halted = 1'b0;
    while (cycles < 500 && !halted) begin
      @(negedge clk);
      cycles++;
      if (imemWordAddr inside {30'd36, 30'd37, 30'd41}) skippedVisits++;
      if (imemWordAddr inside {30'd51, 30'd54, 30'd55}) skippedVisits++;
      if (imemWordAddr == 30'(HALT_WORD)) halted = 1'b1;
    end
    check("R2", "program reached halt word", {31'b0, halted}, 32'd1);
    check("R10", "skipped words visited", skippedVisits, 32'd0);
    repeat (3) @(negedge clk);
    check("R11", "j holds at halt word", {2'b0, imemWordAddr}, HALT_WORD);

    for (int k = 0; k < N_EXP; k++)
      check(tagFor(k), $sformatf("data word %0d", k), dmem[k], EXP_MEM[k]);

    check("R8", "store strobe count", wrCount, 32'd20);
    check("R8", "loaded word untouched", dmem[21], 32'h22222222);

    rst = 1'b1;
    @(negedge clk);
    check("R1", "word address after mid-run reset", {2'b0, imemWordAddr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "advance by one word", {2'b0, imemWordAddr}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule